// File: doc/BRIEF.md
# Beat-Sliced Vector Execution Sequencer

This block carries out one 128-bit vector integer operation as a series of four 32-bit beats. A pulse on the start input captures the operation: add or subtract, the element size, a load flag, a 16-bit byte predicate and a destination register index. While the block is busy it runs one architectural tick per clock cycle. In each tick it retires one, two or four beats, as chosen by a rate input that it samples again at every tick, so the rate can change partway through an operation.

Each retiring beat takes a 32-bit slice from each of the two source operands and computes the lane result. The slice is then written through a register-file write port that carries per-byte enables. Predicated-off bytes of an arithmetic operation are left disabled, so the destination keeps its old contents there. In load mode the result is the first operand, which carries the loaded data. Predicated-off load bytes are enabled and written as zero.

The surrounding datapath holds both source operands stable while busy is high. A one-cycle done pulse follows the last write.

Top module: `vbeat_seq`

## Requirements
- R1: When `start_i` is high while `busy_o` is low, the operation fields are captured at that clock edge, `busy_o` is high in the next cycle with `beat_o` equal to 0, and the first tick takes place in that cycle.
- R2: Beat j covers bytes 4j to 4j+3 of the 128-bit vectors. A tick writes to `wr_addr_o`, and only the bytes of the beats it retires may be enabled.
- R3: `rate_i` is sampled in every tick. Code 0 retires 1 beat, code 1 retires 2 beats, and codes 2 and 3 retire 4 beats. Beats retire in ascending order, and `beat_o` shows the index of the first beat of the current tick.
- R4: A tick never retires beyond beat 4. The beat count is cut to the beats that remain, and `beat_o` holds 4 after completion until the next start.
- R5: `op_sub_i`=0 selects add and 1 selects subtract (A minus B). `esize_i` selects the element size: 0 for 8 bits, 1 for 16 bits, 2 or 3 for 32 bits. Results wrap modulo the element width.
- R6: Carries and borrows never cross an element boundary, so they never cross a beat boundary either.
- R7: Bit k of `pred_i` governs byte k, whatever the element size. For a non-load operation a predicated-off byte is not enabled, so the destination byte keeps its old value.
- R8: With `is_load_i`=1 every byte of a retired beat is enabled. The data is the byte of `src_a_i` where the predicate is set, and zero where it is clear.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last write tick, and `busy_o` is low in that cycle.
- R10: `start_i` has no effect while `busy_o` is high. The running operation keeps its destination, fields and beat sequence.
- R11: A synchronous active-low reset clears `busy_o`, `done_o` and `beat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, honoured only when idle |
| op_sub_i | input | 1 | 0 add, 1 subtract |
| esize_i | input | 2 | Element size code |
| is_load_i | input | 1 | Load mode flag |
| pred_i | input | 16 | Per-byte predicate |
| dst_i | input | 4 | Destination register index |
| rate_i | input | 2 | Beats-per-tick code, sampled every tick |
| src_a_i | input | 128 | First operand, or load data |
| src_b_i | input | 128 | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| beat_o | output | 3 | Current beat index |
| wr_en_o | output | 1 | Write port enable |
| wr_addr_o | output | 4 | Write port register index |
| wr_data_o | output | 128 | Write data |
| wr_be_o | output | 16 | Write byte enables |

## Verification
The bench builds the block with its default parameters: a 128-bit vector, 32-bit beats and a 4-bit register index. This gives exactly four beats of four bytes each, so every rate code can be reached. That includes code 3, which is clamped to four beats, and rate sequences that leave a tick starting on an odd beat, where a request for four beats must be cut short. With four bytes per beat, 8-bit and 16-bit elements sit several to a beat while a 32-bit element fills a whole beat, so wrap-around at every element size lands right on a beat edge.

// File: rtl/vbeat_pkg.sv
// Package vbeat_pkg
// Shared types for the beat-sliced vector sequencer.
// Assumes element-size codes above 2 behave as 32-bit elements.
package vbeat_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2
    } esize_e;

    typedef struct packed {
        logic       sub;
        logic [1:0] esize;
        logic       load;
    } vop_ctl_t;

endpackage

// File: rtl/vbeat_ctrl.sv
// Module vbeat_ctrl
// Start/busy/done sequencing and the beat counter. Each busy cycle is
// one tick. The tick retires beats [lo, hi), where the count comes from
// rate_i and is cut to the beats that remain.
// Assumes NBEATS is a power of two.
module vbeat_ctrl #(
    parameter int NBEATS = 4,
    parameter int CNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       rate_i,
    output logic             take_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] lo_o,
    output logic [CNT_W-1:0] hi_o
);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] beat_q;

    // Accept a start only while idle.
    assign take_o = start_i && !busy_q;

    // Work out the end of the current tick's beat range.
    always_comb begin
        int rb;
        int room;
        int n;
        rb = 1 << rate_i;
        if (rb > NBEATS) rb = NBEATS;
        room = NBEATS - int'(beat_q);
        n = (rb < room) ? rb : room;
        hi_o = CNT_W'(int'(beat_q) + n);
    end

    // Advance the beat counter and produce the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            beat_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (take_o) begin
                busy_q <= 1'b1;
                beat_q <= '0;
            end else if (busy_q) begin
                beat_q <= hi_o;
                if (hi_o == CNT_W'(NBEATS)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign lo_o   = beat_q;

endmodule

// File: rtl/vbeat_lane_alu.sv
// Module vbeat_lane_alu
// Integer add or subtract on one beat slice. The carry chain restarts at
// every element boundary, so no carry leaves an element.
// Assumes the beat width is a whole number of 32-bit words.
module vbeat_lane_alu #(
    parameter int BEAT_W = 32
) (
    input  logic [BEAT_W-1:0] a_i,
    input  logic [BEAT_W-1:0] b_i,
    input  logic              sub_i,
    input  logic [1:0]        esize_i,
    output logic [BEAT_W-1:0] y_o
);

    localparam int BBYTES = BEAT_W / 8;

    // Byte-wise ripple with the carry reset at element starts.
    always_comb begin
        logic       c;
        logic       cin;
        logic       first;
        logic [7:0] bv;
        logic [8:0] s;
        c = 1'b0;
        y_o = '0;
        for (int k = 0; k < BBYTES; k++) begin
            case (esize_i)
                2'd0:    first = 1'b1;
                2'd1:    first = (k % 2) == 0;
                default: first = (k % 4) == 0;
            endcase
            cin = first ? sub_i : c;
            bv = b_i[8*k +: 8] ^ {8{sub_i}};
            s = {1'b0, a_i[8*k +: 8]} + {1'b0, bv} + {8'b0, cin};
            y_o[8*k +: 8] = s[7:0];
            c = s[8];
        end
    end

endmodule

// File: rtl/vbeat_wrmask.sv
// Module vbeat_wrmask
// Builds the write data and byte enables for one beat. Arithmetic bytes
// are enabled only where the predicate is set. Load bytes are always
// enabled and carry zero where the predicate is clear.
// Assumes active_i is low for beats outside the current tick.
module vbeat_wrmask #(
    parameter int BBYTES = 4
) (
    input  logic              active_i,
    input  logic              load_i,
    input  logic [BBYTES-1:0] pred_i,
    input  logic [8*BBYTES-1:0] alu_i,
    input  logic [8*BBYTES-1:0] ld_i,
    output logic [8*BBYTES-1:0] data_o,
    output logic [BBYTES-1:0] be_o
);

    // Per-byte selection of enable and data.
    always_comb begin
        for (int k = 0; k < BBYTES; k++) begin
            be_o[k] = active_i && (pred_i[k] || load_i);
            if (!active_i)
                data_o[8*k +: 8] = 8'h00;
            else if (load_i)
                data_o[8*k +: 8] = pred_i[k] ? ld_i[8*k +: 8] : 8'h00;
            else
                data_o[8*k +: 8] = alu_i[8*k +: 8];
        end
    end

endmodule

// File: rtl/vbeat_seq.sv
// Module vbeat_seq
// Top of the beat-sliced sequencer. It captures an operation on start,
// then in each busy cycle retires the beats chosen by the controller and
// drives the register-file write port with per-byte enables.
// Assumes src_a_i and src_b_i stay stable while busy_o is high.
module vbeat_seq #(
    parameter int VEC_W  = 128,
    parameter int BEAT_W = 32,
    parameter int REG_AW = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start_i,
    input  logic                                   op_sub_i,
    input  logic [1:0]                             esize_i,
    input  logic                                   is_load_i,
    input  logic [VEC_W/8-1:0]                     pred_i,
    input  logic [REG_AW-1:0]                      dst_i,
    input  logic [1:0]                             rate_i,
    input  logic [VEC_W-1:0]                       src_a_i,
    input  logic [VEC_W-1:0]                       src_b_i,
    output logic                                   busy_o,
    output logic                                   done_o,
    output logic [$clog2(VEC_W/BEAT_W+1)-1:0]      beat_o,
    output logic                                   wr_en_o,
    output logic [REG_AW-1:0]                      wr_addr_o,
    output logic [VEC_W-1:0]                       wr_data_o,
    output logic [VEC_W/8-1:0]                     wr_be_o
);
    import vbeat_pkg::*;

    localparam int NBEATS = VEC_W / BEAT_W;
    localparam int BBYTES = BEAT_W / 8;
    localparam int VBYTES = VEC_W / 8;
    localparam int CNT_W  = $clog2(NBEATS + 1);

    logic             take;
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hi;
    vop_ctl_t         ctl_q;
    logic [VBYTES-1:0] pred_q;
    logic [REG_AW-1:0] dst_q;

    vbeat_ctrl #(
        .NBEATS(NBEATS),
        .CNT_W (CNT_W)
    ) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .rate_i (rate_i),
        .take_o (take),
        .busy_o (busy_o),
        .done_o (done_o),
        .lo_o   (lo),
        .hi_o   (hi)
    );

    // Capture the operation fields when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            pred_q <= '0;
            dst_q  <= '0;
        end else if (take) begin
            ctl_q.sub   <= op_sub_i;
            ctl_q.esize <= esize_i;
            ctl_q.load  <= is_load_i;
            pred_q      <= pred_i;
            dst_q       <= dst_i;
        end
    end

    genvar j;
    generate
        for (j = 0; j < NBEATS; j++) begin : g_beat
            logic              active;
            logic [BEAT_W-1:0] alu_y;

            assign active = busy_o && (CNT_W'(j) >= lo) && (CNT_W'(j) < hi);

            vbeat_lane_alu #(.BEAT_W(BEAT_W)) alu_i (
                .a_i    (src_a_i[j*BEAT_W +: BEAT_W]),
                .b_i    (src_b_i[j*BEAT_W +: BEAT_W]),
                .sub_i  (ctl_q.sub),
                .esize_i(ctl_q.esize),
                .y_o    (alu_y)
            );

            vbeat_wrmask #(.BBYTES(BBYTES)) wm_i (
                .active_i(active),
                .load_i  (ctl_q.load),
                .pred_i  (pred_q[j*BBYTES +: BBYTES]),
                .alu_i   (alu_y),
                .ld_i    (src_a_i[j*BEAT_W +: BEAT_W]),
                .data_o  (wr_data_o[j*BEAT_W +: BEAT_W]),
                .be_o    (wr_be_o[j*BBYTES +: BBYTES])
            );
        end
    endgenerate

    assign beat_o    = lo;
    assign wr_en_o   = busy_o;
    assign wr_addr_o = dst_q;

endmodule

// File: rtl/vbeat_seq_chk.sv
// Module vbeat_seq_chk
// Temporal checks on the sequencer ports, bound into every vbeat_seq.
module vbeat_seq_chk #(
    parameter int NBEATS = 4,
    parameter int CNT_W  = 3,
    parameter int REG_AW = 4,
    parameter int VBYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  beat_o,
    input logic              wr_en_o,
    input logic [REG_AW-1:0] wr_addr_o,
    input logic [VBYTES-1:0] wr_be_o
);

    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && beat_o == '0));

    a_r4_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
        beat_o <= CNT_W'(NBEATS));

    a_r1_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && beat_o == '0));

    a_r3_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (beat_o > $past(beat_o)));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(wr_en_o) && !busy_o));

    a_r10_dst_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(wr_addr_o));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (wr_be_o == '0));

endmodule

bind vbeat_seq vbeat_seq_chk #(
    .NBEATS(NBEATS),
    .CNT_W (CNT_W),
    .REG_AW(REG_AW),
    .VBYTES(VBYTES)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .beat_o   (beat_o),
    .wr_en_o  (wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_be_o  (wr_be_o)
);

// File: tb/vbeat_seq_tb.sv
`timescale 1ns/1ps
// Directed bench for vbeat_seq: one task per scenario, each task checks
// its own results against a reference model kept in the bench.
module vbeat_seq_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         op_sub_i = 1'b0;
    logic [1:0]   esize_i = 2'd0;
    logic         is_load_i = 1'b0;
    logic [15:0]  pred_i = '1;
    logic [3:0]   dst_i = '0;
    logic [1:0]   rate_i = 2'd0;
    logic [127:0] src_a_i = '0;
    logic [127:0] src_b_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [2:0]   beat_o;
    logic         wr_en_o;
    logic [3:0]   wr_addr_o;
    logic [127:0] wr_data_o;
    logic [15:0]  wr_be_o;

    int checks = 0;
    int errors = 0;

    logic [127:0] mirror [16];
    int           ticks;
    int           tick_lo [8];
    int           bad_addr;

    vbeat_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sub_i(op_sub_i),
        .esize_i(esize_i), .is_load_i(is_load_i), .pred_i(pred_i),
        .dst_i(dst_i), .rate_i(rate_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .busy_o(busy_o), .done_o(done_o), .beat_o(beat_o), .wr_en_o(wr_en_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference lane arithmetic computed element by element.
    function automatic logic [127:0] ref_alu(input logic [127:0] a, input logic [127:0] b,
                                             input bit sub, input logic [1:0] esz);
        logic [127:0] r;
        r = '0;
        case (esz)
            2'd0: for (int i = 0; i < 16; i++)
                r[8*i +: 8] = sub ? a[8*i +: 8] - b[8*i +: 8] : a[8*i +: 8] + b[8*i +: 8];
            2'd1: for (int i = 0; i < 8; i++)
                r[16*i +: 16] = sub ? a[16*i +: 16] - b[16*i +: 16] : a[16*i +: 16] + b[16*i +: 16];
            default: for (int i = 0; i < 4; i++)
                r[32*i +: 32] = sub ? a[32*i +: 32] - b[32*i +: 32] : a[32*i +: 32] + b[32*i +: 32];
        endcase
        return r;
    endfunction

    function automatic logic [127:0] ref_result(input logic [127:0] old, input logic [127:0] a,
                                                input logic [127:0] b, input bit sub,
                                                input logic [1:0] esz, input bit ld,
                                                input logic [15:0] pr);
        logic [127:0] alu;
        logic [127:0] r;
        alu = ref_alu(a, b, sub, esz);
        r = old;
        for (int k = 0; k < 16; k++) begin
            if (ld) r[8*k +: 8] = pr[k] ? a[8*k +: 8] : 8'h00;
            else if (pr[k]) r[8*k +: 8] = alu[8*k +: 8];
        end
        return r;
    endfunction

    // Run one operation; rates holds one 2-bit code per tick, poke asserts
    // start with a different destination during the first tick.
    task automatic run_op(input bit sub, input logic [1:0] esz, input bit ld,
                          input logic [15:0] pr, input logic [3:0] dst,
                          input logic [127:0] a, input logic [127:0] b,
                          input logic [7:0] rates, input bit poke, input string req);
        logic [127:0] exp;
        @(negedge clk);
        mirror[dst] = 128'h5a5a_a5a5_1234_5678_9abc_def0_0f1e_2d3c;
        exp = ref_result(mirror[dst], a, b, sub, esz, ld, pr);
        op_sub_i = sub; esize_i = esz; is_load_i = ld; pred_i = pr; dst_i = dst;
        src_a_i = a; src_b_i = b; start_i = 1'b1; rate_i = rates[1:0];
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        ticks = 0;
        bad_addr = 0;
        while (busy_o && ticks < 8) begin
            rate_i = rates[2*ticks +: 2];
            if (poke && ticks == 0) begin
                start_i = 1'b1;
                dst_i = dst ^ 4'h1;
                op_sub_i = ~sub;
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (wr_addr_o != dst) bad_addr++;
            for (int k = 0; k < 16; k++)
                if (wr_en_o && wr_be_o[k]) mirror[wr_addr_o][8*k +: 8] = wr_data_o[8*k +: 8];
            tick_lo[ticks] = int'(beat_o);
            ticks++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(mirror[dst] == exp, {req, " result"}, mirror[dst], exp);
        chk(done_o && !busy_o, "R9 done pulse after last tick", {126'b0, done_o, busy_o}, 128'h2);
        chk(beat_o == 3'd4, "R4 beat count holds 4 at end", 128'(beat_o), 128'd4);
        chk(bad_addr == 0, "R2 write address", 128'(bad_addr), 128'd0);
        @(negedge clk);
        chk(!done_o, "R9 done lasts one cycle", 128'(done_o), 128'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy_o && !done_o && beat_o == 0 && wr_be_o == 0, "R11 reset state",
            {107'b0, busy_o, done_o, beat_o, wr_be_o}, 128'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_add8_fast();
        // 8-bit wrap: 0xFF + 0x01 in every byte gives zero, no carry into the next byte (R6)
        run_op(1'b0, 2'd0, 1'b0, 16'hffff, 4'd3, {16{8'hff}}, {16{8'h01}}, 8'hAA, 1'b0,
               "R5 R6 add8 wrap");
        chk(ticks == 1, "R3 rate code 2 one tick", 128'(ticks), 128'd1);
        run_op(1'b0, 2'd0, 1'b0, 16'hffff, 4'd4, 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff,
               128'h0f0f_0f0f_f0f0_f0f0_1234_5678_9abc_def0, 8'hFF, 1'b0, "R5 add8 mixed");
        chk(ticks == 1, "R3 rate code 3 clamps to four beats", 128'(ticks), 128'd1);
    endtask

    task automatic t_sub16_rate2();
        run_op(1'b1, 2'd1, 1'b0, 16'hffff, 4'd5, 128'h0000_0001_8000_7fff_1234_0000_ffff_0100,
               128'h0001_0001_0001_ffff_4321_0001_0001_0001, 8'h55, 1'b0, "R5 R6 sub16");
        chk(ticks == 2 && tick_lo[0] == 0 && tick_lo[1] == 2, "R3 rate 2 ascending beats",
            128'(ticks * 16 + tick_lo[1]), 128'(2 * 16 + 2));
    endtask

    task automatic t_add32_rate1();
        run_op(1'b0, 2'd2, 1'b0, 16'hffff, 4'd6, {4{32'hffff_ffff}}, {4{32'h0000_0001}},
               8'h00, 1'b0, "R6 add32 carry stays in beat");
        chk(ticks == 4 && tick_lo[3] == 3, "R2 R3 one beat per tick",
            128'(ticks * 16 + tick_lo[3]), 128'(4 * 16 + 3));
        run_op(1'b1, 2'd2, 1'b0, 16'hffff, 4'd7, 128'h0000_0000_8000_0000_0000_0005_ffff_fffe,
               128'h0000_0001_0000_0001_0000_0007_ffff_ffff, 8'h00, 1'b0, "R5 sub32 borrow");
    endtask

    task automatic t_rate_change();
        // ticks: 1 beat, 2 beats, then a 4-beat request cut to the one left
        run_op(1'b0, 2'd1, 1'b0, 16'hffff, 4'd8, 128'h1111_2222_3333_4444_5555_6666_7777_8888,
               128'h0101_0202_0303_0404_0505_0606_0707_0808, 8'b00_10_01_00, 1'b0, "R3 varying rate");
        chk(ticks == 3 && tick_lo[1] == 1 && tick_lo[2] == 3, "R4 tick cut at beat 4",
            128'(ticks * 256 + tick_lo[1] * 16 + tick_lo[2]), 128'(3 * 256 + 16 + 3));
        run_op(1'b0, 2'd0, 1'b0, 16'hffff, 4'd9, {8{16'h7f80}}, {8{16'h0180}},
               8'b00_00_10_00, 1'b0, "R3 slow then fast");
        chk(ticks == 2 && tick_lo[1] == 1, "R4 three beats retired in last tick",
            128'(ticks * 16 + tick_lo[1]), 128'(2 * 16 + 1));
    endtask

    task automatic t_pred_arith();
        run_op(1'b0, 2'd1, 1'b0, 16'b1010_0110_0000_1111, 4'd10, {8{16'h00ff}}, {8{16'h0001}},
               8'h55, 1'b0, "R7 masked bytes unchanged");
        run_op(1'b1, 2'd0, 1'b0, 16'h0000, 4'd11, {16{8'h33}}, {16{8'h11}},
               8'hAA, 1'b0, "R7 empty predicate");
    endtask

    task automatic t_pred_load();
        run_op(1'b0, 2'd2, 1'b1, 16'b0011_1100_1000_0001, 4'd12,
               128'hdead_beef_cafe_f00d_0123_4567_89ab_cdef, {16{8'hff}}, 8'h00, 1'b0,
               "R8 load zeroes masked bytes");
    endtask

    task automatic t_start_busy();
        run_op(1'b0, 2'd0, 1'b0, 16'hffff, 4'd2, {16{8'h10}}, {16{8'h03}}, 8'h00, 1'b1,
               "R10 start ignored while busy");
        chk(ticks == 4, "R10 beat sequence undisturbed", 128'(ticks), 128'd4);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rate_i = 2'd0; start_i = 1'b1; dst_i = 4'd1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(busy_o && beat_o == 3'd1, "R1 busy with beat advanced", 128'({busy_o, beat_o}), 128'h9);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!busy_o && !done_o && beat_o == 0, "R11 reset during operation",
            128'({busy_o, done_o, beat_o}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o, "R11 stays idle after reset", 128'({busy_o, done_o}), 128'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mirror[i] = '0;
        t_reset();
        t_add8_fast();
        t_sub16_rate2();
        t_add32_rate1();
        t_rate_change();
        t_pred_arith();
        t_pred_load();
        t_start_busy();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=completed");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule